// File: doc/BRIEF.md
# Address-Window Chip-Select and Bus-Mode Decoder

This block sits between an internal transaction source and a shared external bus. For each transaction it is offered (an address, a flag telling program-space fetches from data-space accesses, and a valid strobe), it decides which of eight chip selects should answer and which bus personality the cycle uses: plain memory cycles, ATA cycles or PCI cycles. It also reports an error when an access falls outside every enabled window. Each transaction is decoded on its own. Back-to-back transactions can therefore move between the three personalities with no reconfiguration in between.

Each chip select owns a window given by a start and a stop address. Chip select 0 has two windows, and only one of them can be on at a time. One is a boot window that can serve instruction fetches. Its reset location is picked by a configuration strap. The other is a window for data only. Two PCI windows of fixed size sit at programmable aligned bases. A simple write port loads all the windows and enables.

The decode is a three-state machine: ST_IDLE (no transaction last cycle), ST_HIT (last transaction matched a window) and ST_MISS (last transaction matched nothing). Every cycle it moves from any state to ST_HIT on a valid access that matches, to ST_MISS on a valid access with no match, and to ST_IDLE when no access is offered. The outputs are registered with the state.

Top module: `cs_window_decoder`

## Requirements
- R1: During reset the chip-select-0 boot window is enabled and covers 512 KB, from 0x0000_0000 when `boot_hi_strap` is 0 or from 0xFFF0_0000 when it is 1. Every other window is disabled, and the outputs are idle: `cs_sel`=0, `bus_mode`=00, `no_hit`=0.
- R2: A chip-select window matches when start <= `req_addr[31:16]` <= stop, with both limits inclusive. A window whose stop is below its start matches nothing.
- R3: A program-space access (`req_prog`=1) can be answered only by the chip-select-0 boot window. The chip-select-0 data window, chip selects 1 to 7 and both PCI windows ignore it. The boot window also answers data-space accesses.
- R4: Writing 1 to the enable of one chip-select-0 window clears the enable of the other. Writing 0 to one of these enables leaves the other unchanged.
- R5: When several windows match, the lowest-numbered chip select wins. Any chip-select match beats a PCI match, and PCI window 0 beats PCI window 1. `cs_sel` is one-hot or zero.
- R6: `bus_mode` encodes 00 as none, 01 as normal, 10 as ATA and 11 as PCI. A chip-select hit gives normal mode, except on chip select 4 or 5 when its ATA bit is set, which gives ATA. ATA bits written for other chip selects have no effect.
- R7: PCI window 0 covers 256 KB at a base aligned to 256 KB, and window 1 covers 1 GB at a base aligned to 1 GB. A PCI hit gives `bus_mode`=11 with `cs_sel`=0.
- R8: A valid access that matches no enabled window gives `no_hit`=1 with `cs_sel`=0 and `bus_mode`=00 for exactly one cycle.
- R9: The results for an access appear on the clock edge after the one that samples `req_valid`. A cycle without `req_valid` returns the outputs to idle. Accesses on consecutive cycles each get their own decode.
- R10: The register map is as follows. Writes take effect from the next cycle, so an access in the same cycle as a write uses the old settings. Address 0 holds the CS0 boot window, 1 to 7 hold CS1 to CS7 and 8 holds the CS0 data window, each packed as {stop[31:16], start[15:0]}. Address 9 bit 0 is the boot enable and address 10 bit 0 is the data enable. In address 11, bit n (1 to 7) enables CSn and bit 8+n is the ATA bit of CSn. Address 12 holds the PCI0 base in bits [31:18] with its enable in bit 0. Address 13 holds the PCI1 base in bits [31:30] with its enable in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_hi_strap | input | 1 | Reset strap: boot window at the top (1) or the bottom (0) of the address space |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Transaction offered this cycle |
| req_addr | input | 32 | Transaction address |
| req_prog | input | 1 | 1 for a program-space fetch, 0 for a data-space access |
| cs_sel | output | 8 | One-hot chip select, bit n for chip select n |
| bus_mode | output | 2 | Bus personality of the decoded access |
| no_hit | output | 1 | Decoded access matched no window |

## Verification
The bench probes each window at its first and last address and one unit past each end, so an off-by-one or an exclusive comparison turns a hit into a miss or the other way round. It sends instruction fetches into data-only windows, where a missing program-space gate would assert a chip select. It also switches between the two chip-select-0 windows and checks that enabling one really turns off the other. It drives overlapping chip-select windows and a PCI window placed over a chip select, where a wrong priority shows up as the wrong select or as PCI mode. A same-cycle write and access shows whether the new settings leak into the decode too early. A second reset with the strap flipped shows whether the boot window follows the strap.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    typedef enum logic [1:0] {
        MODE_NONE   = 2'b00,
        MODE_NORMAL = 2'b01,
        MODE_ATA    = 2'b10,
        MODE_PCI    = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_HIT  = 2'b01,
        ST_MISS = 2'b10
    } dec_state_e;

    localparam int unsigned REG_CS0_DATA = 8;
    localparam int unsigned REG_BOOT_EN  = 9;
    localparam int unsigned REG_DATA_EN  = 10;
    localparam int unsigned REG_CS_EN    = 11;
    localparam int unsigned REG_PCI0     = 12;
    localparam int unsigned REG_PCI1     = 13;
    localparam int unsigned ATA_SHIFT    = 8;

endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
#(
    parameter int unsigned NUM_CS     = 8,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CMP_W      = 16,
    parameter int unsigned CFG_AW     = 4,
    parameter int unsigned BOOT_LOG2  = 19,
    parameter int unsigned PCI0_LOG2  = 18,
    parameter int unsigned PCI1_LOG2  = 30,
    parameter logic [ADDR_W-1:0] BOOT_HI_BASE = 32'hFFF0_0000,
    parameter logic [NUM_CS-1:0] ATA_MASK     = 8'b0011_0000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          boot_hi_strap,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    output logic [NUM_CS:0][CMP_W-1:0]    win_start,
    output logic [NUM_CS:0][CMP_W-1:0]    win_stop,
    output logic [NUM_CS:0]               win_en,
    output logic [NUM_CS-1:0]             ata_en,
    output logic [ADDR_W-1:0]             pci_base0,
    output logic [ADDR_W-1:0]             pci_base1,
    output logic [1:0]                    pci_en
);

    localparam int unsigned LOW_W      = ADDR_W - CMP_W;
    localparam logic [CMP_W-1:0] BOOT_UNITS = CMP_W'(1) << (BOOT_LOG2 - LOW_W);
    localparam logic [ADDR_W-1:0] PCI0_MASK =
        ~((ADDR_W'(1) << PCI0_LOG2) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] PCI1_MASK =
        ~((ADDR_W'(1) << PCI1_LOG2) - ADDR_W'(1));

    logic [CMP_W-1:0] boot_lo;
    assign boot_lo = boot_hi_strap ? BOOT_HI_BASE[ADDR_W-1 -: CMP_W] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= NUM_CS; i++) begin
                win_start[i] <= '0;
                win_stop[i]  <= '0;
            end
            win_start[0] <= boot_lo;
            win_stop[0]  <= boot_lo + BOOT_UNITS - CMP_W'(1);
            win_en       <= '0;
            win_en[0]    <= 1'b1;
            ata_en       <= '0;
            pci_base0    <= '0;
            pci_base1    <= '0;
            pci_en       <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i <= NUM_CS; i++) begin
                if (cfg_addr == CFG_AW'(i)) begin
                    win_start[i] <= cfg_wdata[CMP_W-1:0];
                    win_stop[i]  <= cfg_wdata[2*CMP_W-1:CMP_W];
                end
            end
            if (cfg_addr == CFG_AW'(REG_BOOT_EN)) begin
                win_en[0] <= cfg_wdata[0];
                if (cfg_wdata[0]) win_en[NUM_CS] <= 1'b0;
            end
            if (cfg_addr == CFG_AW'(REG_DATA_EN)) begin
                win_en[NUM_CS] <= cfg_wdata[0];
                if (cfg_wdata[0]) win_en[0] <= 1'b0;
            end
            if (cfg_addr == CFG_AW'(REG_CS_EN)) begin
                for (int i = 1; i < NUM_CS; i++) begin
                    win_en[i] <= cfg_wdata[i];
                end
                ata_en <= cfg_wdata[ATA_SHIFT +: NUM_CS] & ATA_MASK;
            end
            if (cfg_addr == CFG_AW'(REG_PCI0)) begin
                pci_base0 <= cfg_wdata & PCI0_MASK;
                pci_en[0] <= cfg_wdata[0];
            end
            if (cfg_addr == CFG_AW'(REG_PCI1)) begin
                pci_base1 <= cfg_wdata & PCI1_MASK;
                pci_en[1] <= cfg_wdata[0];
            end
        end
    end

endmodule

// File: rtl/csdec_match.sv
module csdec_match #(
    parameter int unsigned NUM_CS    = 8,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned CMP_W     = 16,
    parameter int unsigned PCI0_LOG2 = 18,
    parameter int unsigned PCI1_LOG2 = 30
) (
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_prog,
    input  logic [NUM_CS:0][CMP_W-1:0] win_start,
    input  logic [NUM_CS:0][CMP_W-1:0] win_stop,
    input  logic [NUM_CS:0]            win_en,
    input  logic [ADDR_W-1:0]          pci_base0,
    input  logic [ADDR_W-1:0]          pci_base1,
    input  logic [1:0]                 pci_en,
    output logic [NUM_CS:0]            win_hit,
    output logic [1:0]                 pci_hit
);

    localparam logic [ADDR_W-1:0] PCI0_MASK =
        ~((ADDR_W'(1) << PCI0_LOG2) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] PCI1_MASK =
        ~((ADDR_W'(1) << PCI1_LOG2) - ADDR_W'(1));

    logic [CMP_W-1:0] addr_hi;
    assign addr_hi = req_addr[ADDR_W-1 -: CMP_W];

    for (genvar g = 0; g <= NUM_CS; g++) begin : g_win
        logic in_range;
        assign in_range = (win_start[g] <= addr_hi) && (addr_hi <= win_stop[g]);
        if (g == 0) begin : g_boot
            assign win_hit[g] = win_en[g] && in_range;
        end else begin : g_data
            assign win_hit[g] = win_en[g] && in_range && !req_prog;
        end
    end

    assign pci_hit[0] = pci_en[0] && !req_prog &&
                        ((req_addr & PCI0_MASK) == pci_base0);
    assign pci_hit[1] = pci_en[1] && !req_prog &&
                        ((req_addr & PCI1_MASK) == pci_base1);

endmodule

// File: rtl/csdec_prio.sv
module csdec_prio
    import csdec_pkg::*;
#(
    parameter int unsigned NUM_CS = 8
) (
    input  logic [NUM_CS:0]   win_hit,
    input  logic [1:0]        pci_hit,
    input  logic [NUM_CS-1:0] ata_en,
    output logic [NUM_CS-1:0] sel,
    output bus_mode_e         mode,
    output logic              any_hit
);

    logic [NUM_CS-1:0] cs_hit;

    always_comb begin
        logic found;
        cs_hit    = win_hit[NUM_CS-1:0];
        cs_hit[0] = win_hit[0] | win_hit[NUM_CS];
        sel       = '0;
        found     = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (!found && cs_hit[i]) begin
                sel[i] = 1'b1;
                found  = 1'b1;
            end
        end
        if (found) begin
            mode = ((sel & ata_en) != '0) ? MODE_ATA : MODE_NORMAL;
        end else if (pci_hit != 2'b00) begin
            mode = MODE_PCI;
        end else begin
            mode = MODE_NONE;
        end
        any_hit = found || (pci_hit != 2'b00);
    end

endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
    import csdec_pkg::*;
#(
    parameter int unsigned NUM_CS    = 8,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned CMP_W     = 16,
    parameter int unsigned CFG_AW    = 4,
    parameter int unsigned BOOT_LOG2 = 19,
    parameter int unsigned PCI0_LOG2 = 18,
    parameter int unsigned PCI1_LOG2 = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_hi_strap,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_prog,
    output logic [NUM_CS-1:0] cs_sel,
    output logic [1:0]        bus_mode,
    output logic              no_hit
);

    logic [NUM_CS:0][CMP_W-1:0] win_start;
    logic [NUM_CS:0][CMP_W-1:0] win_stop;
    logic [NUM_CS:0]            win_en;
    logic [NUM_CS-1:0]          ata_en;
    logic [ADDR_W-1:0]          pci_base0;
    logic [ADDR_W-1:0]          pci_base1;
    logic [1:0]                 pci_en;
    logic [NUM_CS:0]            win_hit;
    logic [1:0]                 pci_hit;
    logic [NUM_CS-1:0]          sel_d;
    bus_mode_e                  mode_d;
    logic                       any_hit;

    dec_state_e state_q, state_d;
    bus_mode_e  mode_q;

    csdec_regs #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .CMP_W(CMP_W), .CFG_AW(CFG_AW),
        .BOOT_LOG2(BOOT_LOG2), .PCI0_LOG2(PCI0_LOG2), .PCI1_LOG2(PCI1_LOG2)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_hi_strap(boot_hi_strap),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .win_start(win_start), .win_stop(win_stop), .win_en(win_en),
        .ata_en(ata_en), .pci_base0(pci_base0), .pci_base1(pci_base1),
        .pci_en(pci_en)
    );

    csdec_match #(
        .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .CMP_W(CMP_W),
        .PCI0_LOG2(PCI0_LOG2), .PCI1_LOG2(PCI1_LOG2)
    ) u_match (
        .req_addr(req_addr), .req_prog(req_prog),
        .win_start(win_start), .win_stop(win_stop), .win_en(win_en),
        .pci_base0(pci_base0), .pci_base1(pci_base1), .pci_en(pci_en),
        .win_hit(win_hit), .pci_hit(pci_hit)
    );

    csdec_prio #(.NUM_CS(NUM_CS)) u_prio (
        .win_hit(win_hit), .pci_hit(pci_hit), .ata_en(ata_en),
        .sel(sel_d), .mode(mode_d), .any_hit(any_hit)
    );

    always_comb begin
        if (!req_valid)    state_d = ST_IDLE;
        else if (any_hit)  state_d = ST_HIT;
        else               state_d = ST_MISS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sel <= '0;
            mode_q <= MODE_NONE;
        end else begin
            unique case (state_d)
                ST_HIT: begin
                    cs_sel <= sel_d;
                    mode_q <= mode_d;
                end
                ST_MISS: begin
                    cs_sel <= '0;
                    mode_q <= MODE_NONE;
                end
                ST_IDLE: begin
                    cs_sel <= '0;
                    mode_q <= MODE_NONE;
                end
            endcase
        end
    end

    assign bus_mode = mode_q;
    assign no_hit   = (state_q == ST_MISS);

endmodule

// File: rtl/csdec_checker.sv
module csdec_checker
    import csdec_pkg::*;
#(
    parameter int unsigned NUM_CS = 8,
    parameter logic [NUM_CS-1:0] ATA_MASK = 8'b0011_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_prog,
    input logic [NUM_CS-1:0] cs_sel,
    input logic [1:0]        bus_mode,
    input logic              no_hit,
    input logic              boot_en,
    input logic              data_en
);

    // R5
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_sel));

    // R8
    miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_hit |-> (cs_sel == '0 && bus_mode == MODE_NONE));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!no_hit && cs_sel == '0 && bus_mode == MODE_NONE));

    // R9
    valid_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (no_hit || bus_mode != MODE_NONE));

    // R3
    prog_cs0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_prog) |=> ((cs_sel >> 1) == '0 && bus_mode != MODE_PCI));

    // R4
    cs0_pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(boot_en && data_en));

    // R6
    ata_cs_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == MODE_ATA) |-> ((cs_sel & ATA_MASK) != '0));

    // R7
    pci_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode == MODE_PCI) |-> (cs_sel == '0));

endmodule

bind cs_window_decoder csdec_checker #(.NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_prog(req_prog),
    .cs_sel(cs_sel), .bus_mode(bus_mode), .no_hit(no_hit),
    .boot_en(win_en[0]), .data_en(win_en[NUM_CS])
);

// File: tb/test_cs_window_decoder.sv
module test_cs_window_decoder;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] M_NONE = 2'b00;
    localparam logic [1:0] M_NORM = 2'b01;
    localparam logic [1:0] M_ATA  = 2'b10;
    localparam logic [1:0] M_PCI  = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_hi_strap = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_prog = 1'b0;
    logic [7:0]  cs_sel;
    logic [1:0]  bus_mode;
    logic        no_hit;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_window_decoder i_cs_window_decoder (
        .clk(clk), .rst_n(rst_n), .boot_hi_strap(boot_hi_strap),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_prog(req_prog),
        .cs_sel(cs_sel), .bus_mode(bus_mode), .no_hit(no_hit)
    );

    task automatic chk(input string tag, input logic [7:0] ecs,
                       input logic [1:0] em, input logic emiss);
        checks++;
        if (cs_sel !== ecs || bus_mode !== em || no_hit !== emiss) begin
            failures++;
            $display("FAIL %s: cs=%h mode=%b miss=%b expected cs=%h mode=%b miss=%b",
                     tag, cs_sel, bus_mode, no_hit, ecs, em, emiss);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic p, input string tag,
                          input logic [7:0] ecs, input logic [1:0] em,
                          input logic emiss);
        req_valid = 1'b1; req_addr = a; req_prog = p;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, ecs, em, emiss);
    endtask

    task automatic do_reset(input logic strap);
        boot_hi_strap = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        chk("R1 idle outputs after reset", 8'h00, M_NONE, 1'b0);
    endtask

    task automatic t_boot_low;
        access(32'h0000_1234, 1'b1, "R1 boot fetch low base", 8'h01, M_NORM, 1'b0);
        access(32'h0007_FFFF, 1'b1, "R2 boot last byte", 8'h01, M_NORM, 1'b0);
        access(32'h0008_0000, 1'b1, "R1 boot span 512KB end", 8'h00, M_NONE, 1'b1);
        access(32'h0000_0010, 1'b0, "R3 boot window serves data", 8'h01, M_NORM, 1'b0);
        access(32'h1000_0000, 1'b0, "R1 cs1 disabled at reset", 8'h00, M_NONE, 1'b1);
    endtask

    task automatic t_prog_gate;
        cfg_write(4'd1, 32'h1000_1000);
        cfg_write(4'd11, 32'h0000_0002);
        access(32'h1000_0004, 1'b1, "R3 fetch ignored by cs1", 8'h00, M_NONE, 1'b1);
        access(32'h1000_0004, 1'b0, "R3 data hits cs1", 8'h02, M_NORM, 1'b0);
        access(32'h0FFF_FFFF, 1'b0, "R2 below start", 8'h00, M_NONE, 1'b1);
        access(32'h1000_FFFF, 1'b0, "R2 stop inclusive", 8'h02, M_NORM, 1'b0);
        access(32'h1001_0000, 1'b0, "R2 above stop", 8'h00, M_NONE, 1'b1);
    endtask

    task automatic t_cs0_pairs;
        cfg_write(4'd8, 32'h2000_2000);
        cfg_write(4'd10, 32'h0000_0001);
        access(32'h0000_0000, 1'b1, "R4 data enable clears boot", 8'h00, M_NONE, 1'b1);
        access(32'h2000_0000, 1'b0, "R4 data window on cs0", 8'h01, M_NORM, 1'b0);
        access(32'h2000_0000, 1'b1, "R3 data window ignores fetch", 8'h00, M_NONE, 1'b1);
        cfg_write(4'd9, 32'h0000_0001);
        access(32'h2000_0000, 1'b0, "R4 boot enable clears data", 8'h00, M_NONE, 1'b1);
        access(32'h0000_0000, 1'b1, "R4 boot back on", 8'h01, M_NORM, 1'b0);
        cfg_write(4'd10, 32'h0000_0000);
        access(32'h0000_0000, 1'b1, "R4 zero write keeps boot", 8'h01, M_NORM, 1'b0);
    endtask

    task automatic t_priority;
        cfg_write(4'd2, 32'h30FF_3000);
        cfg_write(4'd3, 32'h31FF_3080);
        cfg_write(4'd11, 32'h0000_000E);
        access(32'h3090_0000, 1'b0, "R5 lower cs wins overlap", 8'h04, M_NORM, 1'b0);
        access(32'h3100_0000, 1'b0, "R5 cs3 alone", 8'h08, M_NORM, 1'b0);
        cfg_write(4'd12, 32'h3000_0001);
        access(32'h3000_0000, 1'b0, "R5 cs beats pci", 8'h04, M_NORM, 1'b0);
        cfg_write(4'd13, 32'hC000_0001);
        cfg_write(4'd12, 32'hC000_0001);
        access(32'hC000_0000, 1'b0, "R5 pci0 beats pci1", 8'h00, M_PCI, 1'b0);
    endtask

    task automatic t_pci;
        cfg_write(4'd12, 32'h4000_0001);
        cfg_write(4'd13, 32'h8000_0001);
        access(32'h4003_FFFF, 1'b0, "R7 pci0 top byte", 8'h00, M_PCI, 1'b0);
        access(32'h4004_0000, 1'b0, "R7 pci0 256KB end", 8'h00, M_NONE, 1'b1);
        access(32'hBFFF_FFFC, 1'b0, "R7 pci1 top word", 8'h00, M_PCI, 1'b0);
        access(32'h7FFF_FFFC, 1'b0, "R7 below pci1", 8'h00, M_NONE, 1'b1);
        access(32'h4000_0000, 1'b1, "R3 pci ignores fetch", 8'h00, M_NONE, 1'b1);
    endtask

    task automatic t_ata;
        cfg_write(4'd4, 32'h50FF_5000);
        cfg_write(4'd5, 32'h51FF_5100);
        cfg_write(4'd6, 32'h52FF_5200);
        cfg_write(4'd11, 32'h0000_F07E);
        access(32'h5000_0000, 1'b0, "R6 cs4 ata", 8'h10, M_ATA, 1'b0);
        access(32'h5100_0000, 1'b0, "R6 cs5 ata", 8'h20, M_ATA, 1'b0);
        access(32'h5200_0000, 1'b0, "R6 cs6 ata bit ignored", 8'h40, M_NORM, 1'b0);
        cfg_write(4'd11, 32'h0000_107E);
        access(32'h5100_0000, 1'b0, "R6 cs5 back to normal", 8'h20, M_NORM, 1'b0);
    endtask

    task automatic t_inverted;
        cfg_write(4'd7, 32'h6000_6100);
        cfg_write(4'd11, 32'h0000_10FE);
        access(32'h6000_0000, 1'b0, "R2 inverted at stop", 8'h00, M_NONE, 1'b1);
        access(32'h6080_0000, 1'b0, "R2 inverted between", 8'h00, M_NONE, 1'b1);
        access(32'h6100_0000, 1'b0, "R2 inverted at start", 8'h00, M_NONE, 1'b1);
    endtask

    task automatic t_switch;
        access(32'h5000_0000, 1'b0, "R9 b2b ata", 8'h10, M_ATA, 1'b0);
        access(32'h4000_0000, 1'b0, "R9 b2b pci", 8'h00, M_PCI, 1'b0);
        access(32'h5200_0000, 1'b0, "R9 b2b normal", 8'h40, M_NORM, 1'b0);
        access(32'hEEEE_0000, 1'b0, "R8 b2b miss", 8'h00, M_NONE, 1'b1);
        @(negedge clk);
        chk("R8 miss lasts one cycle", 8'h00, M_NONE, 1'b0);
    endtask

    task automatic t_cfg_timing;
        cfg_we = 1'b1; cfg_addr = 4'd11; cfg_wdata = 32'h0000_10FC;
        access(32'h1000_0000, 1'b0, "R10 same-cycle write uses old", 8'h02, M_NORM, 1'b0);
        cfg_we = 1'b0;
        access(32'h1000_0000, 1'b0, "R10 write visible next", 8'h00, M_NONE, 1'b1);
    endtask

    task automatic t_strap_high;
        do_reset(1'b1);
        chk("R1 idle after strap reset", 8'h00, M_NONE, 1'b0);
        access(32'hFFF0_0000, 1'b1, "R1 boot high base", 8'h01, M_NORM, 1'b0);
        access(32'hFFF7_FFFF, 1'b1, "R1 boot high last", 8'h01, M_NORM, 1'b0);
        access(32'hFFEF_FFFF, 1'b1, "R1 below high base", 8'h00, M_NONE, 1'b1);
        access(32'hFFF8_0000, 1'b1, "R1 past high span", 8'h00, M_NONE, 1'b1);
        access(32'h0000_0000, 1'b1, "R1 low base unused", 8'h00, M_NONE, 1'b1);
        access(32'h5000_0000, 1'b0, "R1 windows cleared", 8'h00, M_NONE, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        t_reset_state();
        t_boot_low();
        t_prog_gate();
        t_cs0_pairs();
        t_priority();
        t_pci();
        t_ata();
        t_inverted();
        t_switch();
        t_cfg_timing();
        t_strap_high();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule